// File: doc/BRIEF.md
# Receive Destination Address Filter with Multicast Hash

This block decides, frame by frame, whether an incoming Ethernet frame is kept. For each frame it takes the frame length at a start strobe, then the six destination address bytes one per cycle. It answers with a one-cycle decision pulse. The pulse carries an accept flag and a group flag, which marks frames accepted as broadcast or hashed multicast for the receive status word. Where the accepted frame is placed in memory is left to other logic.

A frame shorter than the configured minimum length is always dropped. Otherwise the frame is classified as follows. Promiscuous mode accepts everything. An all-ones destination is broadcast. Any other destination with the group bit set goes through a 64-bin hash table. The remaining unicast addresses must match the station address exactly.

The hash table is built by a separate loader. The loader takes a byte count and then a stream of multicast addresses. It runs a byte-serial CRC-32 over each address and sets the bin that the CRC selects.

Top module: `rx_addr_filter`

## Requirements
- R1: Reset clears `decValid`, `decAccept`, `decGroup` and empties the hash table, so that a group-addressed frame with `cfgMcastOn=1` is rejected after reset.
- R2: Destination bytes are taken while `frmByteValid` is high, first byte first. The sixth byte is sampled at clock edge k, and `decValid` is high for exactly the one cycle after edge k+1. Bytes beyond the sixth are ignored until the next `frmStart`. A `frmStart` restarts the byte count and discards a partial address.
- R3: A frame whose `frmLen` is below max(`cfgMinLen`, 5) is rejected with group 0, before any address check and regardless of mode.
- R4: With `cfgPromisc=1`, every frame that is long enough is accepted with group 0.
- R5: An all-ones destination is accepted with group 1 when `cfgBcastOff=0`, and rejected when `cfgBcastOff=1`.
- R6: A destination that is not all ones and has bit 0 of its first byte set is rejected when `cfgMcastOn=0`.
- R7: With `cfgMcastOn=1`, such a destination is accepted with group 1 exactly when table bin crc[7:2] is set. Here crc is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, least significant bit of each byte first, no final inversion) over the six address bytes in wire order.
- R8: Any other destination is accepted with group 0 only when it equals `stationAddr`. The first wire byte is compared with `stationAddr[7:0]` and the sixth with `stationAddr[47:40]`.
- R9: `mcStart` clears the whole table and sets the entry count to floor(`mcByteCnt`/6), capped at 64. Each complete group of six `mcByte` bytes sets one bin. Bytes after the last counted entry are ignored.
- R10: `decAccept` and `decGroup` are low whenever `decValid` is low, and `decGroup` is never high without `decAccept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgPromisc | input | 1 | Accept every frame of valid length |
| cfgBcastOff | input | 1 | Reject all-ones destinations |
| cfgMcastOn | input | 1 | Allow hashed group addresses |
| cfgMinLen | input | 8 | Minimum frame length, floored at 5 |
| stationAddr | input | 48 | Own unicast address, first wire byte in bits 7:0 |
| frmStart | input | 1 | Start of a frame; latches `frmLen` |
| frmLen | input | 14 | Frame length in bytes |
| frmByteValid | input | 1 | `frmByte` carries a destination byte |
| frmByte | input | 8 | Destination address byte |
| mcStart | input | 1 | Start of a multicast list; latches `mcByteCnt` |
| mcByteCnt | input | 16 | List length in bytes |
| mcByteValid | input | 1 | `mcByte` carries a list byte |
| mcByte | input | 8 | Multicast list byte |
| decValid | output | 1 | One-cycle decision strobe |
| decAccept | output | 1 | Frame is kept |
| decGroup | output | 1 | Frame was kept as broadcast or multicast |

## Verification
The bench builds the block with its default parameters: a 64-bin table indexed by CRC bits 7:2, a 64-entry list cap, 14-bit lengths and a 16-bit byte count. With these values, a list of 70 addresses and a byte count of 0xFFFF both reach the 64-entry cap within a short run. The floor of 5 on the minimum length is reached by setting `cfgMinLen` to 0 or 3. Multicast expectations come from a bench CRC model of the streamed list, so table clearing, the entry cap and hash collisions are checked at the ports.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

  localparam int ADDR_BYTES = 6;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

  // strobes from control to datapath
  typedef struct packed {
    logic frmBegin;
    logic frmShift;
    logic listBegin;
    logic listShift;
    logic listCommit;
    logic decide;
  } strobes_t;

  function automatic logic [31:0] crcByte(input logic [31:0] crcIn, input logic [7:0] data);
    logic [31:0] c;
    logic fb;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ data[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/rx_addr_filter_ctrl.sv
module rx_addr_filter_ctrl
  import rx_addr_filter_pkg::*;
#(
  parameter int MAX_ENTRIES = 64,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frmStart,
  input  logic             frmByteValid,
  input  logic             mcStart,
  input  logic [CNT_W-1:0] mcByteCnt,
  input  logic             mcByteValid,
  output strobes_t         stb
);

  localparam int CNTF_W = $clog2(ADDR_BYTES + 1);
  localparam int ENT_W  = $clog2(MAX_ENTRIES + 1);

  logic [CNTF_W-1:0] frmCnt;
  logic [CNTF_W-1:0] byteIdx;
  logic [ENT_W-1:0]  entriesLeft;
  logic              decidePend;

  logic [CNT_W-1:0]  entryRaw;
  logic [ENT_W-1:0]  entryCap;
  logic takeFrm, lastByte, takeList, entryDone;

  always_comb begin
    entryRaw  = mcByteCnt / CNT_W'(ADDR_BYTES);
    entryCap  = (entryRaw > CNT_W'(MAX_ENTRIES)) ? ENT_W'(MAX_ENTRIES) : entryRaw[ENT_W-1:0];
    takeFrm   = !frmStart && frmByteValid && (frmCnt != CNTF_W'(ADDR_BYTES));
    lastByte  = takeFrm && (frmCnt == CNTF_W'(ADDR_BYTES - 1));
    takeList  = !mcStart && mcByteValid && (entriesLeft != '0);
    entryDone = takeList && (byteIdx == CNTF_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frmCnt      <= '0;
      byteIdx     <= '0;
      entriesLeft <= '0;
      decidePend  <= 1'b0;
    end else begin
      decidePend <= lastByte;
      if (frmStart) frmCnt <= '0;
      else if (takeFrm) frmCnt <= frmCnt + 1'b1;
      if (mcStart) begin
        entriesLeft <= entryCap;
        byteIdx     <= '0;
      end else if (takeList) begin
        if (entryDone) begin
          byteIdx     <= '0;
          entriesLeft <= entriesLeft - 1'b1;
        end else begin
          byteIdx <= byteIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb.frmBegin   = frmStart;
    stb.frmShift   = takeFrm;
    stb.listBegin  = mcStart;
    stb.listShift  = takeList;
    stb.listCommit = entryDone;
    stb.decide     = decidePend;
  end

  // R9
  entry_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    entriesLeft <= ENT_W'(MAX_ENTRIES));

  // R2
  frm_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    frmCnt <= CNTF_W'(ADDR_BYTES));

  // R2
  decide_after_six_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.decide |-> frmCnt == CNTF_W'(ADDR_BYTES));

endmodule

// File: rtl/rx_addr_filter_dp.sv
module rx_addr_filter_dp
  import rx_addr_filter_pkg::*;
#(
  parameter int LEN_W     = 14,
  parameter int MINLEN_W  = 8,
  parameter int HASH_W    = 6,
  parameter int FLOOR_LEN = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobes_t              stb,
  input  logic                  cfgPromisc,
  input  logic                  cfgBcastOff,
  input  logic                  cfgMcastOn,
  input  logic [MINLEN_W-1:0]   cfgMinLen,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic [LEN_W-1:0]      frmLen,
  input  logic [7:0]            frmByte,
  input  logic [7:0]            mcByte,
  output logic                  decValid,
  output logic                  decAccept,
  output logic                  decGroup
);

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int BINS   = 2 ** HASH_W;
  localparam int CMP_W  = (LEN_W > MINLEN_W) ? LEN_W : MINLEN_W;

  logic [LEN_W-1:0]  lenReg;
  logic [ADDR_W-1:0] destReg;
  logic [31:0]       frmCrc, listCrc, listCrcNext;
  logic [BINS-1:0]   hashTable;

  logic [CMP_W-1:0]  effMin;
  logic tooShort, isBcast, hashHit, nextAccept, nextGroup;

  always_comb begin
    listCrcNext = crcByte(listCrc, mcByte);
    effMin   = (CMP_W'(cfgMinLen) < CMP_W'(FLOOR_LEN)) ? CMP_W'(FLOOR_LEN) : CMP_W'(cfgMinLen);
    tooShort = CMP_W'(lenReg) < effMin;
    isBcast  = &destReg;
    hashHit  = hashTable[frmCrc[HASH_W+1:2]];
    nextAccept = 1'b0;
    nextGroup  = 1'b0;
    if (tooShort) begin
      nextAccept = 1'b0;
    end else if (cfgPromisc) begin
      nextAccept = 1'b1;
    end else if (isBcast) begin
      nextAccept = !cfgBcastOff;
      nextGroup  = !cfgBcastOff;
    end else if (destReg[0]) begin
      nextAccept = cfgMcastOn && hashHit;
      nextGroup  = cfgMcastOn && hashHit;
    end else begin
      nextAccept = (destReg == stationAddr);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenReg    <= '0;
      destReg   <= '0;
      frmCrc    <= CRC_INIT;
      listCrc   <= CRC_INIT;
      hashTable <= '0;
      decValid  <= 1'b0;
      decAccept <= 1'b0;
      decGroup  <= 1'b0;
    end else begin
      if (stb.frmBegin) begin
        lenReg  <= frmLen;
        destReg <= '0;
        frmCrc  <= CRC_INIT;
      end else if (stb.frmShift) begin
        destReg <= {frmByte, destReg[ADDR_W-1:8]};
        frmCrc  <= crcByte(frmCrc, frmByte);
      end
      if (stb.listBegin) begin
        hashTable <= '0;
        listCrc   <= CRC_INIT;
      end else if (stb.listShift) begin
        if (stb.listCommit) begin
          hashTable[listCrcNext[HASH_W+1:2]] <= 1'b1;
          listCrc <= CRC_INIT;
        end else begin
          listCrc <= listCrcNext;
        end
      end
      decValid  <= stb.decide;
      decAccept <= stb.decide && nextAccept;
      decGroup  <= stb.decide && nextGroup;
    end
  end

  // R2
  dec_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid |=> !decValid);

  // R10
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (!decAccept && !decGroup));

  // R10
  group_needs_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    decGroup |-> decAccept);

  // R4
  promisc_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(cfgPromisc) && !$past(tooShort)) |-> (decAccept && !decGroup));

  // R3
  short_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && $past(tooShort)) |-> !decAccept);

  // R9
  list_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.listBegin |=> hashTable == '0);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int LEN_W       = 14,
  parameter int MINLEN_W    = 8,
  parameter int CNT_W       = 16,
  parameter int HASH_W      = 6,
  parameter int MAX_ENTRIES = 64,
  parameter int FLOOR_LEN   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgPromisc,
  input  logic                cfgBcastOff,
  input  logic                cfgMcastOn,
  input  logic [MINLEN_W-1:0] cfgMinLen,
  input  logic [47:0]         stationAddr,
  input  logic                frmStart,
  input  logic [LEN_W-1:0]    frmLen,
  input  logic                frmByteValid,
  input  logic [7:0]          frmByte,
  input  logic                mcStart,
  input  logic [CNT_W-1:0]    mcByteCnt,
  input  logic                mcByteValid,
  input  logic [7:0]          mcByte,
  output logic                decValid,
  output logic                decAccept,
  output logic                decGroup
);

  strobes_t stb;

  rx_addr_filter_ctrl #(
    .MAX_ENTRIES(MAX_ENTRIES),
    .CNT_W      (CNT_W)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .frmStart    (frmStart),
    .frmByteValid(frmByteValid),
    .mcStart     (mcStart),
    .mcByteCnt   (mcByteCnt),
    .mcByteValid (mcByteValid),
    .stb         (stb)
  );

  rx_addr_filter_dp #(
    .LEN_W    (LEN_W),
    .MINLEN_W (MINLEN_W),
    .HASH_W   (HASH_W),
    .FLOOR_LEN(FLOOR_LEN)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgPromisc (cfgPromisc),
    .cfgBcastOff(cfgBcastOff),
    .cfgMcastOn (cfgMcastOn),
    .cfgMinLen  (cfgMinLen),
    .stationAddr(stationAddr),
    .frmLen     (frmLen),
    .frmByte    (frmByte),
    .mcByte     (mcByte),
    .decValid   (decValid),
    .decAccept  (decAccept),
    .decGroup   (decGroup)
  );

endmodule

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgPromisc, cfgBcastOff, cfgMcastOn;
  logic [7:0]  cfgMinLen;
  logic [47:0] stationAddr;
  logic        frmStart, frmByteValid, mcStart, mcByteValid;
  logic [13:0] frmLen;
  logic [7:0]  frmByte, mcByte;
  logic [15:0] mcByteCnt;
  logic        decValid, decAccept, decGroup;

  int total = 0;
  int bad   = 0;
  logic [63:0] model;

  always #4 clk = ~clk;

  rx_addr_filter uut (
    .clk(clk), .rstN(rstN),
    .cfgPromisc(cfgPromisc), .cfgBcastOff(cfgBcastOff), .cfgMcastOn(cfgMcastOn),
    .cfgMinLen(cfgMinLen), .stationAddr(stationAddr),
    .frmStart(frmStart), .frmLen(frmLen), .frmByteValid(frmByteValid), .frmByte(frmByte),
    .mcStart(mcStart), .mcByteCnt(mcByteCnt), .mcByteValid(mcByteValid), .mcByte(mcByte),
    .decValid(decValid), .decAccept(decAccept), .decGroup(decGroup)
  );

  localparam logic [47:0] STATION = 48'h554433221102;

  typedef struct packed {
    logic [3:0]  req;
    logic        pr, bo, mo;
    logic [7:0]  minLen;
    logic [13:0] len;
    logic [47:0] dest;
    logic        acc, grp;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{4'd8, 1'b0,1'b0,1'b0, 8'd64, 14'd64, 48'h554433221102, 1'b1,1'b0}, // R8 match
    '{4'd8, 1'b0,1'b0,1'b0, 8'd64, 14'd64, 48'h564433221102, 1'b0,1'b0}, // R8 last byte off
    '{4'd8, 1'b0,1'b0,1'b0, 8'd64, 14'd64, 48'h554433221106, 1'b0,1'b0}, // R8 first byte off
    '{4'd5, 1'b0,1'b0,1'b0, 8'd64, 14'd64, 48'hFFFFFFFFFFFF, 1'b1,1'b1}, // R5 broadcast
    '{4'd5, 1'b0,1'b1,1'b0, 8'd64, 14'd64, 48'hFFFFFFFFFFFF, 1'b0,1'b0}, // R5 disabled
    '{4'd6, 1'b0,1'b0,1'b0, 8'd64, 14'd64, 48'h0100005e0001, 1'b0,1'b0}, // R6 mcast off
    '{4'd1, 1'b0,1'b0,1'b1, 8'd64, 14'd64, 48'h0100005e0001, 1'b0,1'b0}, // R1 empty table
    '{4'd4, 1'b1,1'b0,1'b0, 8'd64, 14'd64, 48'h998877665544, 1'b1,1'b0}, // R4 promisc
    '{4'd4, 1'b1,1'b1,1'b0, 8'd64, 14'd64, 48'hFFFFFFFFFFFF, 1'b1,1'b0}, // R4 promisc bcast
    '{4'd3, 1'b0,1'b0,1'b0, 8'd64, 14'd63, 48'h554433221102, 1'b0,1'b0}, // R3 one short
    '{4'd3, 1'b0,1'b0,1'b0, 8'd0,  14'd4,  48'h554433221102, 1'b0,1'b0}, // R3 floor 5
    '{4'd3, 1'b0,1'b0,1'b0, 8'd0,  14'd5,  48'h554433221102, 1'b1,1'b0}, // R3 at floor
    '{4'd3, 1'b1,1'b0,1'b0, 8'd64, 14'd10, 48'h998877665544, 1'b0,1'b0}, // R3 before promisc
    '{4'd3, 1'b0,1'b0,1'b1, 8'd3,  14'd5,  48'hFFFFFFFFFFFF, 1'b1,1'b1}  // R3 min below floor
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] benchHash(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int b = 0; b < 48; b++) begin
      if ((c[0] ^ a[b]) == 1'b1) c = (c >> 1) ^ 32'hEDB88320;
      else c = c >> 1;
    end
    return c[7:2];
  endfunction

  function automatic logic [47:0] mcAddr(input int i);
    logic [7:0] a = i[7:0];
    return {8'h77, a ^ 8'h5a, a, 8'h5e, 8'h00, 8'h01};
  endfunction

  // drives one frame; checks R2 timing; returns decision
  task automatic sendFrame(input logic [13:0] len, input logic [47:0] dest,
                           output logic acc, output logic grp);
    @(negedge clk);
    frmStart = 1'b1; frmLen = len;
    @(negedge clk);
    frmStart = 1'b0;
    for (int i = 0; i < 6; i++) begin
      frmByteValid = 1'b1; frmByte = dest[8*i +: 8];
      @(negedge clk);
    end
    frmByteValid = 1'b0;
    chk("R2 no early valid", decValid, 0);
    @(negedge clk);
    chk("R2 valid pulse", decValid, 1);
    acc = decAccept; grp = decGroup;
    @(negedge clk);
    chk("R2 pulse ends", decValid, 0);
  endtask

  task automatic loadList(input logic [15:0] cnt, input int nAddr, input int base);
    int ent;
    @(negedge clk);
    mcStart = 1'b1; mcByteCnt = cnt;
    @(negedge clk);
    mcStart = 1'b0;
    for (int i = 0; i < nAddr; i++) begin
      for (int b = 0; b < 6; b++) begin
        mcByteValid = 1'b1; mcByte = mcAddr(base + i) >> (8*b);
        @(negedge clk);
      end
    end
    mcByteValid = 1'b0;
    ent = cnt / 6;
    if (ent > 64) ent = 64;
    model = '0;
    for (int i = 0; i < nAddr && i < ent; i++) model[benchHash(mcAddr(base + i))] = 1'b1;
  endtask

  task automatic checkMc(input int idx);
    logic a, g, e;
    sendFrame(14'd64, mcAddr(idx), a, g);
    e = model[benchHash(mcAddr(idx))];
    chk("R7 R9 hashed accept", a, e);
    chk("R7 hashed group", g, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, g;
    rstN = 1'b0;
    cfgPromisc = 0; cfgBcastOff = 0; cfgMcastOn = 0; cfgMinLen = 8'd64;
    stationAddr = STATION;
    frmStart = 0; frmLen = '0; frmByteValid = 0; frmByte = '0;
    mcStart = 0; mcByteCnt = '0; mcByteValid = 0; mcByte = '0;
    model = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", decValid, 0);
    chk("R1 reset accept", decAccept, 0);
    chk("R1 reset group", decGroup, 0);

    for (int v = 0; v < NVEC; v++) begin
      cfgPromisc = VECS[v].pr; cfgBcastOff = VECS[v].bo; cfgMcastOn = VECS[v].mo;
      cfgMinLen = VECS[v].minLen;
      sendFrame(VECS[v].len, VECS[v].dest, a, g);
      total++;
      if (a !== VECS[v].acc || g !== VECS[v].grp) begin
        bad++;
        $display("FAIL R%0d vector %0d actual=%b%b expected=%b%b",
                 VECS[v].req, v, a, g, VECS[v].acc, VECS[v].grp);
      end
    end

    cfgPromisc = 0; cfgBcastOff = 0; cfgMcastOn = 1; cfgMinLen = 8'd64;

    // R2 bytes after the sixth are ignored
    for (int i = 0; i < 4; i++) begin
      frmByteValid = 1'b1; frmByte = 8'hFF;
      @(negedge clk);
      chk("R2 extra bytes ignored", decValid, 0);
    end
    frmByteValid = 1'b0;

    // R2 restart discards a partial broadcast address
    @(negedge clk);
    frmStart = 1'b1; frmLen = 14'd64;
    @(negedge clk);
    frmStart = 1'b0;
    for (int i = 0; i < 3; i++) begin
      frmByteValid = 1'b1; frmByte = 8'hFF;
      @(negedge clk);
      chk("R2 partial no decision", decValid, 0);
    end
    frmByteValid = 1'b0;
    sendFrame(14'd64, 48'h0000000000AA, a, g);
    chk("R2 restart new address", {a, g}, 2'b00);
    sendFrame(14'd64, STATION, a, g);
    chk("R2 restart station", {a, g}, 2'b10);

    // R7 single entry
    loadList(16'd6, 1, 1);
    checkMc(1);
    for (int j = 2; j < 40; j++) begin
      if (benchHash(mcAddr(j)) != benchHash(mcAddr(1))) begin
        checkMc(j);
        break;
      end
    end
    // R9 reload clears previous entries
    loadList(16'd6, 1, 50);
    checkMc(1);
    checkMc(50);
    // R9 count 13 -> two entries, third ignored
    loadList(16'd13, 3, 100);
    for (int j = 100; j < 103; j++) checkMc(j);
    // R9 cap at 64 entries
    loadList(16'd420, 70, 0);
    for (int j = 60; j < 70; j++) checkMc(j);
    loadList(16'hFFFF, 66, 120);
    for (int j = 182; j < 186; j++) checkMc(j);
    // R6 table set but multicast disabled
    cfgMcastOn = 0;
    sendFrame(14'd64, mcAddr(120), a, g);
    chk("R6 disabled with table", {a, g}, 2'b00);
    cfgMcastOn = 1;

    // R1 reset empties the table
    loadList(16'd6, 1, 7);
    checkMc(7);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    model = '0;
    sendFrame(14'd64, mcAddr(7), a, g);
    chk("R1 table empty after reset", {a, g}, 2'b00);
    // R10 outputs quiet between decisions
    chk("R10 quiet accept", decAccept, 0);
    chk("R10 quiet group", decGroup, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule